// File: doc/BRIEF.md
# Crossbar Slave Priority Register Bank

This block is the configuration store that sits in front of one slave port of a multi-master crossbar. It keeps a 4-bit arbitration level for every master that is present and drives those levels out to the slave port's arbiter. It also holds a control register with a single lock bit. Once the lock bit is set, the priority assignment is frozen until the next reset.

Software reaches the block through a simple register bus with these signals: a valid strobe, a write enable, an offset inside the slave's 256-byte window, write data, byte strobes, a registered acknowledge, an error flag and read data. Every access is answered exactly one cycle later. The block checks every write to the priority register before it commits it. Writes that are partial, that are out of range, that repeat a level or that arrive while the bank is locked are refused with an error, and the stored state does not change. The parameter `NUM_MST` sets how many masters exist, from 2 to 8.

Top module: `xbar_prio_regs`

## Requirements
- R1: After reset, the 4-bit field at bits [4n+3:4n] of `prio_out` holds the value n for each present master n. With eight masters this is 0x7654_3210. The lock is clear and no acknowledge is pending.
- R2: A read at offset 0x00 with all four strobes set returns the priority register on `rsp_rdata`. The data appears with `rsp_ack` in the cycle after the request, and `rsp_err` is low.
- R3: A read at offset 0x10 returns the control register. The lock is at bit 31 and every other bit reads as zero.
- R4: A write at offset 0x00 with all four strobes set and a legal value is accepted without error. The new levels appear on `prio_out` in the same cycle as the acknowledge.
- R5: Any access at offset 0x00 whose strobes are not all four set (`req_be` not 4'b1111) returns an error and leaves the register unchanged.
- R6: A write that gives the same level to two or more present masters returns an error and leaves the register unchanged.
- R7: A write that gives any present master a level of `NUM_MST` or more returns an error and leaves the register unchanged.
- R8: A control write with bit 31 set and `req_be[3]` set sets the lock. The lock then stays set until reset. While the lock is set, every control write returns an error.
- R9: While the lock is set, every write to offset 0x00 returns an error and changes nothing. Reads of offset 0x00 still succeed.
- R10: The fields for absent masters (index `NUM_MST` and above) always read as zero. Write data in those fields is ignored, including by the duplicate and range checks.
- R11: An access to any offset other than 0x00 and 0x10 returns an error with zero read data.
- R12: Every request cycle is followed by exactly one acknowledge cycle, and there is no acknowledge otherwise. `rsp_err` is only high together with `rsp_ack`. `rsp_rdata` is zero for writes and for failed accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the slave's window |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte strobes |
| rsp_ack | output | 1 | Access completed (one cycle after the request) |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data |
| prio_out | output | 4*NUM_MST | Current level of each master, toward the arbiter |
| locked | output | 1 | Lock bit state |

## Verification
The response assertions assume that a request is a single-cycle pulse. They also assume that a new request may follow in the very next cycle, which means the bus has no wait states and no request ever overlaps a pending one. The bench drives each access for exactly one cycle, from the falling edge, and drops `req_valid` after every access. This keeps every stimulus within that assumption. It also relies on `NUM_MST` being small enough to sweep: with four masters the bench writes all 65,536 patterns of the priority field and carries varying junk in the unused upper bits.

// File: rtl/xbar_prio_regs.sv
module xbar_prio_regs #(
  parameter int NUM_MST = 8,
  parameter int ADDR_W  = 8,
  localparam int PW     = 4 * NUM_MST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [PW-1:0]     prio_out,
  output logic              locked
);

  localparam logic [ADDR_W-1:0] OFS_PRIO = '0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h10);

  function automatic logic [PW-1:0] reset_levels();
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_MST; i++) r[4*i +: 4] = 4'(i);
    return r;
  endfunction

  function automatic logic levels_ok(input logic [PW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_MST; i++) begin
      if ({1'b0, v[4*i +: 4]} >= 5'(NUM_MST)) ok = 1'b0;
      for (int j = 0; j < i; j++)
        if (v[4*i +: 4] == v[4*j +: 4]) ok = 1'b0;
    end
    return ok;
  endfunction

  logic [PW-1:0] prio_q;
  logic          lock_q;
  logic          hit_prio, hit_ctrl, full, err_c, wr_prio, set_lock;
  logic [31:0]   prio_word, rd_c;
  wire           unused_wdata = ^req_wdata;

  assign hit_prio = req_addr == OFS_PRIO;
  assign hit_ctrl = req_addr == OFS_CTRL;
  assign full     = &req_be;

  always_comb begin
    prio_word = '0;
    prio_word[PW-1:0] = prio_q;
  end

  always_comb begin
    err_c = 1'b0;
    if (!hit_prio && !hit_ctrl)
      err_c = 1'b1;
    else if (hit_prio)
      err_c = !full || (req_write && (lock_q || !levels_ok(req_wdata[PW-1:0])));
    else
      err_c = req_write && lock_q;
  end

  assign wr_prio  = req_valid && req_write && hit_prio && !err_c;
  assign set_lock = req_valid && req_write && hit_ctrl && !err_c
                    && req_be[3] && req_wdata[31];

  always_comb begin
    rd_c = '0;
    if (!req_write && !err_c)
      rd_c = hit_prio ? prio_word : {lock_q, 31'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q    <= reset_levels();
      lock_q    <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_prio)  prio_q <= req_wdata[PW-1:0];
      if (set_lock) lock_q <= 1'b1;
      rsp_ack   <= req_valid;
      rsp_err   <= req_valid && err_c;
      rsp_rdata <= req_valid ? rd_c : '0;
    end
  end

  assign prio_out = prio_q;
  assign locked   = lock_q;

endmodule

// File: rtl/xbar_prio_regs_chk.sv
module xbar_prio_regs_chk #(
  parameter int NUM_MST = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 rsp_ack,
  input logic                 rsp_err,
  input logic [4*NUM_MST-1:0] prio_out,
  input logic                 locked
);

  function automatic logic has_dup(input logic [4*NUM_MST-1:0] v);
    logic d;
    d = 1'b0;
    for (int i = 0; i < NUM_MST; i++)
      for (int j = 0; j < i; j++)
        if (v[4*i +: 4] == v[4*j +: 4]) d = 1'b1;
    return d;
  endfunction

  function automatic logic has_big(input logic [4*NUM_MST-1:0] v);
    logic b;
    b = 1'b0;
    for (int i = 0; i < NUM_MST; i++)
      if ({1'b0, v[4*i +: 4]} >= 5'(NUM_MST)) b = 1'b1;
    return b;
  endfunction

  AST_ACK_AFTER_REQ:   assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_ack);              // R12
  AST_NO_STRAY_ACK:    assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_ack);            // R12
  AST_ERR_WITH_ACK:    assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> rsp_ack);                // R12
  AST_LOCK_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked);                  // R8
  AST_LOCKED_FROZEN:   assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(prio_out));       // R9
  AST_UPDATE_ACKED:    assert property (@(posedge clk) disable iff (!rst_n) !$stable(prio_out) |-> rsp_ack && !rsp_err); // R4
  AST_LEVELS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n) !has_dup(prio_out));                 // R6
  AST_LEVELS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !has_big(prio_out));                 // R7

endmodule

bind xbar_prio_regs xbar_prio_regs_chk #(.NUM_MST(NUM_MST)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ack(rsp_ack),
  .rsp_err(rsp_err), .prio_out(prio_out), .locked(locked)
);

// File: tb/test_xbar_prio_regs.sv
`timescale 1ns/1ps
module test_xbar_prio_regs;
  localparam int NM = 4;
  localparam int PW = 4 * NM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic rsp_ack, rsp_err, locked;
  logic [31:0] rsp_rdata;
  logic [PW-1:0] prio_out;

  int checks = 0, errors = 0;
  logic [PW-1:0] exp_prio;

  always #10 clk = ~clk;

  xbar_prio_regs #(.NUM_MST(NM), .ADDR_W(8)) i_xbar_prio_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .prio_out(prio_out), .locked(locked));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic legal(input logic [15:0] v);
    for (int i = 0; i < NM; i++) begin
      if (((v >> (4*i)) & 16'hF) >= NM) return 1'b0;
      for (int j = 0; j < i; j++)
        if (((v >> (4*i)) & 16'hF) == ((v >> (4*j)) & 16'hF)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic exp_err, input logic [31:0] exp_rd,
                        input string req);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " R12 ack"}, 32'(rsp_ack), 32'd1);
    chk({req, " err"}, 32'(rsp_err), 32'(exp_err));
    chk({req, " rdata"}, rsp_rdata, exp_rd);
    chk({req, " prio_out"}, 32'(prio_out), 32'(exp_prio));
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_prio = 16'h3210;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset prio", 32'(prio_out), 32'h3210);
    chk("R1 reset lock", 32'(locked), 32'd0);
    chk("R1 reset ack", 32'(rsp_ack), 32'd0);

    access(1'b0, 8'h00, '0, 4'hF, 1'b0, 32'h3210, "R2 read prio");
    access(1'b0, 8'h10, '0, 4'hF, 1'b0, 32'h0, "R3 read ctrl");
    @(negedge clk);
    chk("R12 idle no ack", 32'(rsp_ack), 32'd0);

    for (int i = 0; i < 65536; i++) begin
      logic [31:0] d;
      logic ok;
      d = {16'((i * 40503) >> 3), 16'(i)};
      ok = legal(16'(i));
      if (ok) exp_prio = 16'(i);
      access(1'b1, 8'h00, d, 4'hF, !ok, 32'h0, ok ? "R4 legal write" : "R6 R7 illegal write");
      if (ok) access(1'b0, 8'h00, '0, 4'hF, 1'b0, {16'h0, 16'(i)}, "R10 absent fields zero");
    end

    for (int b = 0; b < 15; b++) begin
      access(1'b1, 8'h00, 32'h0000_0123, 4'(b), 1'b1, 32'h0, "R5 partial write");
      access(1'b0, 8'h00, '0, 4'(b), 1'b1, 32'h0, "R5 partial read");
    end

    for (int a = 0; a < 256; a++) begin
      if (a == 0 || a == 16) continue;
      access(1'(a & 1), 8'(a), 32'h0000_0123, 4'hF, 1'b1, 32'h0, "R11 unmapped");
    end

    access(1'b1, 8'h10, 32'h7FFF_FFFF, 4'hF, 1'b0, 32'h0, "R8 ctrl write no lock");
    access(1'b1, 8'h10, 32'h8000_0000, 4'h7, 1'b0, 32'h0, "R8 lock needs strobe");
    chk("R8 still unlocked", 32'(locked), 32'd0);
    access(1'b0, 8'h10, '0, 4'hF, 1'b0, 32'h0, "R3 ctrl other bits zero");
    access(1'b1, 8'h10, 32'h8000_0000, 4'hF, 1'b0, 32'h0, "R8 set lock");
    chk("R8 locked", 32'(locked), 32'd1);
    access(1'b0, 8'h10, '0, 4'hF, 1'b0, 32'h8000_0000, "R3 read lock bit");
    access(1'b1, 8'h10, 32'h0, 4'hF, 1'b1, 32'h0, "R8 ctrl write when locked");
    chk("R8 lock sticky", 32'(locked), 32'd1);

    for (int i = 0; i < 24; i++) begin
      logic [15:0] v;
      v = {4'(i % 4), 4'((i + 1) % 4), 4'((i + 2) % 4), 4'((i + 3) % 4)};
      access(1'b1, 8'h00, {16'h0, v}, 4'hF, 1'b1, 32'h0, "R9 locked write");
      access(1'b0, 8'h00, '0, 4'hF, 1'b0, {16'h0, exp_prio}, "R9 locked read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule